// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycle of an 8-bit processor with a 16-bit address space whose low address byte and data byte share one set of eight bidirectional pins. An internal requester presents an address, write data, a direction bit and a space bit (memory or I/O). The block then steps the pins through a three-state cycle, T1 to T3, and returns the read byte together with a one-cycle done strobe. The upper address byte leaves on dedicated output-only lines. The shared byte carries the low address first and data afterwards. A latch-enable pulse marks the address phase so that an external latch can split the two.

The block has a single input clock, `xin`. It divides this clock by two and drives the result out as the system clock. Each bus state covers one system-clock period, which is two `xin` cycles: a low half (phase 0) followed by a high half (phase 1). The states are named IDLE, T1, T2 and T3. The transitions are IDLE→T1 when a request is accepted, T1→T2 and T2→T3 at the end of each state, and T3→IDLE at the end of the cycle. All of these moves happen on the `xin` edge that closes phase 1. Every pin output comes straight from a register. A model of the demultiplexing latch is included, and its captured address is brought out as a port.

Top module: `muxbus_ctrl`

## Requirements
- R1: `sys_clk_o` is 0 during reset and toggles on every rising `xin` edge after reset, so it runs at half the `xin` frequency.
- R2: A request is taken only on a rising `xin` edge where `req_valid` and `req_ready` are both 1. `req_ready` is 1 only in IDLE while `sys_clk_o` is 1. A request held while the block is busy starts no cycle.
- R3: In the first `xin` cycle after acceptance (T1, phase 0), `ale_o` is 1, `ad_io` carries address bits 7:0 and `addr_hi_o` carries address bits 15:8. In the second cycle `ale_o` is 0 while the address stays on the pins.
- R4: From the end of T1 until the next latch-enable pulse, `lat_addr_o` equals the 16-bit request address.
- R5: On a read, the block releases `ad_io` from T2 onward. `rd_n_o` is 0 for exactly two `xin` cycles (T2 phase 1 and T3 phase 0). The block never drives `ad_io` while `rd_n_o` is 0.
- R6: The byte on `ad_io` in the last cycle of the read strobe appears on `rsp_rdata`. `rsp_done` is 1 for exactly one `xin` cycle, which is the sixth cycle after the accepting edge (T3 phase 1).
- R7: On a write, the write byte is on `ad_io` from the start of T2 to the end of T3. `wr_n_o` is 0 for T2 phase 1 and T3 phase 0, so the data is valid one `xin` cycle before the strobe falls and one cycle after it rises.
- R8: `io_m_o` is 0 for a memory access and 1 for an I/O access. It holds that value from T1 through T3.
- R9: `rd_n_o` and `wr_n_o` are never 0 at the same time. Both are 1, and `ad_io` is released, whenever the block is in IDLE.
- R10: While `rst_n` is 0 (sampled on the rising `xin` edge), the block returns to IDLE with `rd_n_o`=1, `wr_n_o`=1, `ale_o`=0, `rsp_done`=0 and `ad_io` released, even if a cycle was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xin | input | 1 | Input clock, divided by two internally |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_ready | output | 1 | Block can take a request on this edge |
| rsp_rdata | output | 8 | Byte captured by the last read |
| rsp_done | output | 1 | One-cycle end-of-cycle strobe |
| addr_hi_o | output | 8 | Upper address byte |
| ad_io | inout | 8 | Shared low-address / data byte |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| io_m_o | output | 1 | Space indicator, 1 = I/O |
| sys_clk_o | output | 1 | Divided system clock |
| lat_addr_o | output | 16 | Address held by the demultiplexing latch model |

## Verification
A wrong state or phase in the sequencer appears at the pins within one `xin` cycle, because every pin output is registered directly from the next state. Three symptoms follow from it: the latch-enable pulse lands in the wrong slot, the strobe window is shifted or lengthened, or `ad_io` still carries address or write data where the bench expects a device byte. A fault in the request capture shows up in the first T1 cycle as a wrong `addr_hi_o` or low address, and one cycle later in `lat_addr_o`. A fault in the read capture shows up in the done cycle as a wrong `rsp_rdata`. A request accepted while busy shows up as a latch-enable pulse during cycles that should stay quiet.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    localparam int HI_W  = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_T1   = 2'd1,
        S_T2   = 2'd2,
        S_T3   = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              io;
    } bus_req_t;
endpackage

// File: rtl/mbc_clkdiv.sv
module mbc_clkdiv (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign phase_o = phase_q;

    AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_q != $past(phase_q)));  // R1
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase,
    input  logic       req_valid,
    input  bus_req_t   req_in,
    output logic       req_ready,
    output bus_state_e state_o,
    output bus_state_e nxt_state_o,
    output bus_req_t   nxt_req_o,
    output logic       cur_write_o
);
    bus_state_e state_q, nxt_state;
    bus_req_t   req_q, nxt_req;
    logic       accept;

    assign accept = phase && (state_q == S_IDLE) && req_valid;

    always_comb begin
        nxt_state = state_q;
        nxt_req   = req_q;
        unique case (state_q)
            S_IDLE: if (accept) begin
                nxt_state = S_T1;
                nxt_req   = req_in;
            end
            S_T1: if (phase) nxt_state = S_T2;
            S_T2: if (phase) nxt_state = S_T3;
            S_T3: if (phase) nxt_state = S_IDLE;
            default: nxt_state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= nxt_state;
            req_q   <= nxt_req;
        end
    end

    assign req_ready   = (state_q == S_IDLE) && phase;
    assign state_o     = state_q;
    assign nxt_state_o = nxt_state;
    assign nxt_req_o   = nxt_req;
    assign cur_write_o = req_q.write;

    AST_T1_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_T1 && !phase) |-> ($past(req_valid) && $past(req_ready)));  // R2
    AST_STATE_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && state_q != S_IDLE) |-> (state_q == $past(state_q)));  // R1
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  bus_state_e        state_q,
    input  bus_state_e        nxt_state,
    input  bus_req_t          nxt_req,
    input  logic              cur_write,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    logic              nxt_ph;
    logic              d_oe, d_ale, d_rd_n, d_wr_n, d_done;
    logic [DATA_W-1:0] d_out;
    logic              oe_q, ale_q, rd_n_q, wr_n_q, done_q, io_q;
    logic [DATA_W-1:0] out_q, rdata_q;
    logic [HI_W-1:0]   hi_q;

    assign nxt_ph = ~phase;

    always_comb begin
        d_oe   = 1'b0;
        d_out  = nxt_req.addr[DATA_W-1:0];
        d_ale  = 1'b0;
        d_rd_n = 1'b1;
        d_wr_n = 1'b1;
        d_done = 1'b0;
        unique case (nxt_state)
            S_IDLE: ;
            S_T1: begin
                d_oe  = 1'b1;
                d_ale = !nxt_ph;
            end
            S_T2: begin
                if (nxt_req.write) begin
                    d_oe   = 1'b1;
                    d_out  = nxt_req.wdata;
                    d_wr_n = !nxt_ph;
                end else begin
                    d_rd_n = !nxt_ph;
                end
            end
            S_T3: begin
                if (nxt_req.write) begin
                    d_oe   = 1'b1;
                    d_out  = nxt_req.wdata;
                    d_wr_n = nxt_ph;
                end else begin
                    d_rd_n = nxt_ph;
                end
                d_done = nxt_ph;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            out_q  <= '0;
            ale_q  <= 1'b0;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            done_q <= 1'b0;
            io_q   <= 1'b0;
            hi_q   <= '0;
        end else begin
            oe_q   <= d_oe;
            out_q  <= d_out;
            ale_q  <= d_ale;
            rd_n_q <= d_rd_n;
            wr_n_q <= d_wr_n;
            done_q <= d_done;
            io_q   <= nxt_req.io;
            hi_q   <= nxt_req.addr[ADDR_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state_q == S_T3 && !phase && !cur_write)
            rdata_q <= ad_in;
    end

    assign ad_out  = out_q;
    assign ad_oe   = oe_q;
    assign ale     = ale_q;
    assign rd_n    = rd_n_q;
    assign wr_n    = wr_n_q;
    assign io_m    = io_q;
    assign addr_hi = hi_q;
    assign rdata   = rdata_q;
    assign done    = done_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_q && !wr_n_q));  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (rd_n_q && wr_n_q && !oe_q));  // R9
    AST_NO_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_q |-> !oe_q);  // R5
    AST_ALE_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ale_q |-> (oe_q && state_q == S_T1));  // R3
    AST_WRITE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_q |-> (oe_q && $stable(out_q)));  // R7
    AST_READ_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n_q) |=> !rd_n_q);  // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);  // R6
    AST_SPACE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_T2 || state_q == S_T3) |-> $stable(io_q));  // R8
endmodule

// File: rtl/mbc_addr_latch.sv
module mbc_addr_latch
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [HI_W-1:0]   addr_hi,
    output logic [ADDR_W-1:0] lat_addr
);
    logic [DATA_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (!rst_n)   lo_q <= '0;
        else if (ale) lo_q <= ad_in;
    end

    assign lat_addr = {addr_hi, lo_q};

    AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (lo_q == $past(ad_in)));  // R4
endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
    import mbc_pkg::*;
(
    input  logic              xin,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [HI_W-1:0]   addr_hi_o,
    inout  wire  [DATA_W-1:0] ad_io,
    output logic              ale_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              io_m_o,
    output logic              sys_clk_o,
    output logic [ADDR_W-1:0] lat_addr_o
);
    logic              phase;
    bus_req_t          req_in;
    bus_state_e        state_q, nxt_state;
    bus_req_t          nxt_req;
    logic              cur_write;
    logic [DATA_W-1:0] ad_out;
    logic              ad_oe;

    assign req_in = '{addr: req_addr, wdata: req_wdata, write: req_write, io: req_io};

    mbc_clkdiv u_div (
        .clk     (xin),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    mbc_seq u_seq (
        .clk         (xin),
        .rst_n       (rst_n),
        .phase       (phase),
        .req_valid   (req_valid),
        .req_in      (req_in),
        .req_ready   (req_ready),
        .state_o     (state_q),
        .nxt_state_o (nxt_state),
        .nxt_req_o   (nxt_req),
        .cur_write_o (cur_write)
    );

    mbc_pins u_pins (
        .clk       (xin),
        .rst_n     (rst_n),
        .phase     (phase),
        .state_q   (state_q),
        .nxt_state (nxt_state),
        .nxt_req   (nxt_req),
        .cur_write (cur_write),
        .ad_in     (ad_io),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .ale       (ale_o),
        .rd_n      (rd_n_o),
        .wr_n      (wr_n_o),
        .io_m      (io_m_o),
        .addr_hi   (addr_hi_o),
        .rdata     (rsp_rdata),
        .done      (rsp_done)
    );

    assign ad_io = ad_oe ? ad_out : {DATA_W{1'bz}};

    mbc_addr_latch u_lat (
        .clk      (xin),
        .rst_n    (rst_n),
        .ale      (ale_o),
        .ad_in    (ad_io),
        .addr_hi  (addr_hi_o),
        .lat_addr (lat_addr_o)
    );

    assign sys_clk_o = phase;
endmodule

// File: tb/sim_muxbus_ctrl.sv
module sim_muxbus_ctrl;
    logic        xin = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_ready, rsp_done, ale_o, rd_n_o, wr_n_o, io_m_o, sys_clk_o;
    logic [7:0]  rsp_rdata, addr_hi_o;
    logic [15:0] lat_addr_o;
    wire  [7:0]  ad_io;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_all = 1'b0;
    logic [7:0] blat = '0;

    always #10 xin = ~xin;

    muxbus_ctrl u0 (
        .xin(xin), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .addr_hi_o(addr_hi_o), .ad_io(ad_io), .ale_o(ale_o), .rd_n_o(rd_n_o),
        .wr_n_o(wr_n_o), .io_m_o(io_m_o), .sys_clk_o(sys_clk_o),
        .lat_addr_o(lat_addr_o)
    );

    function automatic logic [7:0] dev_byte(input logic [15:0] a, input logic io);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (io ? 8'hA5 : 8'h3C);
    endfunction

    // bench-side peripheral: own address latch, drives only while read strobe low
    always @(posedge xin) if (ale_o) blat <= ad_io;
    assign ad_io = (!rd_n_o) ? dev_byte({addr_hi_o, blat}, io_m_o) : 8'bz;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act %0h exp %0h", tag, act, exp);
        end
    endtask

    // continuous protocol monitor
    always @(negedge xin) begin
        if (rst_n && !done_all) begin
            chk(!(!rd_n_o && !wr_n_o), "R9 dual strobe", {rd_n_o, wr_n_o}, 2'b11);
            if (req_ready) chk(sys_clk_o, "R2 ready only with sys_clk high", sys_clk_o, 1);
        end
    end

    always @(posedge xin) begin
        cyc++;
        if (cyc == 150000 && !done_all) begin
            errors++;
            $display("FAIL R2 watchdog act %0d exp below 150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_txn(input logic [15:0] a, input logic [7:0] d,
                           input bit w, input bit io, input bit poke);
        logic [7:0] exp_rd;
        exp_rd = dev_byte(a, io);
        @(negedge xin);
        while (!req_ready) @(negedge xin);
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = w; req_io = io;
        @(negedge xin);                                   // T1 phase 0
        req_valid = 1'b0;
        req_addr = ~a; req_wdata = ~d; req_io = ~io;
        chk(ale_o == 1'b1, "R3 ale high in T1", ale_o, 1);
        chk(addr_hi_o == a[15:8], "R3 upper address", addr_hi_o, a[15:8]);
        chk(ad_io == a[7:0], "R3 low address on shared pins", ad_io, a[7:0]);
        chk(io_m_o == io, "R8 space indicator", io_m_o, io);
        @(negedge xin);                                   // T1 phase 1
        chk(ale_o == 1'b0, "R3 ale low second half", ale_o, 0);
        chk(ad_io == a[7:0], "R3 address held", ad_io, a[7:0]);
        chk(lat_addr_o == a, "R4 latched address", lat_addr_o, a);
        if (poke) begin
            req_valid = 1'b1; req_addr = 16'h5A5A; req_write = 1'b0;
        end
        @(negedge xin);                                   // T2 phase 0
        if (w) begin
            chk(ad_io == d, "R7 data before strobe", ad_io, d);
            chk(wr_n_o == 1'b1, "R7 write strobe not yet low", wr_n_o, 1);
        end else begin
            chk(rd_n_o == 1'b1, "R5 read strobe not yet low", rd_n_o, 1);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge xin);                               // T2 ph1, T3 ph0
            if (w) begin
                chk(wr_n_o == 1'b0, "R7 write strobe low", wr_n_o, 0);
                chk(ad_io == d, "R7 data held", ad_io, d);
                chk(rd_n_o == 1'b1, "R9 read idle during write", rd_n_o, 1);
            end else begin
                chk(rd_n_o == 1'b0, "R5 read strobe low", rd_n_o, 0);
                chk(ad_io == exp_rd, "R5 pins free for device", ad_io, exp_rd);
                chk(wr_n_o == 1'b1, "R9 write idle during read", wr_n_o, 1);
            end
            chk(rsp_done == 1'b0, "R6 no early done", rsp_done, 0);
            chk(io_m_o == io, "R8 space held", io_m_o, io);
        end
        @(negedge xin);                                   // T3 phase 1
        chk(rsp_done == 1'b1, "R6 done in sixth cycle", rsp_done, 1);
        chk(rd_n_o && wr_n_o, "R5 strobes released", {rd_n_o, wr_n_o}, 2'b11);
        if (w) chk(ad_io == d, "R7 data after strobe", ad_io, d);
        else   chk(rsp_rdata == exp_rd, "R6 read data", rsp_rdata, exp_rd);
        @(negedge xin);                                   // IDLE
        chk(rsp_done == 1'b0, "R6 done single cycle", rsp_done, 0);
        if (poke) begin
            req_valid = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(negedge xin);
                chk(ale_o == 1'b0, "R2 busy request ignored", ale_o, 0);
            end
        end
    endtask

    initial begin
        logic prev;
        void'($urandom(32'd4242));
        repeat (3) @(negedge xin);
        chk(rd_n_o && wr_n_o, "R10 strobes high in reset", {rd_n_o, wr_n_o}, 2'b11);
        chk(ale_o == 1'b0, "R10 ale low in reset", ale_o, 0);
        chk(rsp_done == 1'b0, "R10 done low in reset", rsp_done, 0);
        chk(sys_clk_o == 1'b0, "R1 divided clock low in reset", sys_clk_o, 0);
        rst_n = 1'b1;
        @(negedge xin);
        prev = sys_clk_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge xin);
            chk(sys_clk_o == ~prev, "R1 divided clock toggles", sys_clk_o, ~prev);
            prev = sys_clk_o;
        end

        run_txn(16'h0000, 8'h00, 1'b1, 1'b0, 1'b0);
        run_txn(16'hFFFF, 8'hFF, 1'b0, 1'b1, 1'b0);
        run_txn(16'h12C4, 8'h81, 1'b1, 1'b1, 1'b0);
        run_txn(16'hA55A, 8'h00, 1'b0, 1'b0, 1'b1);

        for (int n = 0; n < 60; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            d = 8'($urandom);
            run_txn(a, d, 1'($urandom), 1'($urandom), 1'b0);
            repeat ($urandom_range(0, 3)) @(negedge xin);
        end

        // reset during an active write strobe
        @(negedge xin);
        while (!req_ready) @(negedge xin);
        req_valid = 1'b1; req_addr = 16'h3344; req_wdata = 8'h99; req_write = 1'b1; req_io = 1'b0;
        @(negedge xin);
        req_valid = 1'b0;
        repeat (3) @(negedge xin);
        chk(wr_n_o == 1'b0, "R7 strobe low before reset", wr_n_o, 0);
        rst_n = 1'b0;
        @(negedge xin);
        chk(rd_n_o && wr_n_o, "R10 strobes released by reset", {rd_n_o, wr_n_o}, 2'b11);
        chk(ale_o == 1'b0 && rsp_done == 1'b0, "R10 ale and done low", {ale_o, rsp_done}, 0);
        chk(req_ready == 1'b0, "R10 divider cleared", req_ready, 0);
        rst_n = 1'b1;
        run_txn(16'h7E01, 8'h3C, 1'b0, 1'b1, 1'b0);

        done_all = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule